// File: doc/BRIEF.md
# DMA Trigger Gating Unit

This block holds back the progress of one DMA channel until an external trigger event has been seen. One line of a trigger vector is picked by a select field, brought into the channel clock domain through a synchronizer chain, and watched for an edge. A polarity field sets which edge counts: rising, falling, or none at all. Each detected edge becomes a single pending hit. The channel sequencer raises a request for each unit of work it is about to start. Of the request kinds it can raise, the gate mode picks one that must spend a pending hit before it is permitted. The other request kinds are permitted at once.

The four gate modes set how coarse the gating is. The coarsest gates only the first burst of each block. The next gates the first burst of each repeated block, on channels built with repeated-block support. The next gates each linked-list descriptor fetch and lets that descriptor's data move freely. The finest gates every programmed burst: the read burst for software-requested transfers, or each peripheral-requested burst for hardware-requested transfers. A hit that arrives while one is already pending is not queued. It is counted in a saturating overrun counter and flagged with a one-cycle pulse.

Top module: `trig_gate_unit`

## Requirements
- R1: While and after reset, no hit is pending, the overrun pulse is low and the overrun count is zero.
- R2: A level change on the selected trigger line is seen through SYNC_STAGES synchronizer flops and one edge register. With the default of 2 stages, a change that is present before clock edge k shows as hit_pending after edge k+2.
- R3: The polarity code works as follows: 1 makes a rising edge a hit, 2 makes a falling edge a hit, and 0 and 3 both mask the trigger so that no hit is ever recorded.
- R4: unit_req/unit_permit bit positions are 0 block-first-burst, 1 repeated-block-first-burst, 2 descriptor fetch, 3 read burst, 4 peripheral burst. Gate mode 0 gates bit 0 only.
- R5: Gate mode 1 gates bit 1 when RPT_CAPABLE is 1. When RPT_CAPABLE is 0 it gates bit 0, as mode 0 does.
- R6: Gate mode 2 gates bit 2 only. Block and burst requests pass ungated.
- R7: Gate mode 3 gates bit 3 when sw_req is 1 and bit 4 when sw_req is 0.
- R8: A request on a bit that the current mode does not gate is permitted in the same cycle. A permit is never given without its request.
- R9: A gated request is permitted only in a cycle where hit_pending is 1. Such a permit consumes the hit, so hit_pending is 0 after that edge unless a new hit arrives.
- R10: A hit while one is already pending and not consumed in that cycle raises overrun for that cycle and adds one to overrun_count, which saturates at its maximum. The extra hit is not queued.
- R11: A hit in the same cycle as a consuming permit leaves exactly one hit pending.
- R12: Edges on trigger lines other than the one selected by trig_sel have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | N_TRIG | Asynchronous trigger lines |
| trig_sel | input | SEL_W | Index of the watched trigger line |
| trig_pol | input | 2 | Edge polarity code |
| gate_mode | input | 2 | Gating granularity |
| sw_req | input | 1 | 1 for a software-requested transfer, 0 for a hardware-requested one |
| unit_req | input | 5 | Start-of-unit requests from the sequencer |
| unit_permit | output | 5 | Per-unit permission to start |
| hit_pending | output | 1 | A trigger hit is waiting to be spent |
| overrun | output | 1 | One-cycle pulse for a hit that was dropped |
| overrun_count | output | CNT_W | Saturating count of dropped hits |

## Verification
Every output is compared on every clock against a behavioural model that keeps its own per-line shift history of the trigger inputs. The gating is exercised in each mode with the gated request held before the trigger arrives, so a wrong choice of gated bit shows up as a permit that comes too early. Trains of edges with no request tell the pending-and-overrun bookkeeping apart from a queue, and drive the counter into saturation. A request placed at several offsets against a fresh edge separates consume-then-set from set-then-consume. Toggling unselected lines and switching through the masked polarity codes confirms that those inputs never create a hit. A second instance built without repeated-block support checks the mode 1 fallback.

// File: rtl/trgate_pkg.sv
package trgate_pkg;

  typedef enum logic [1:0] {
    POL_OFF     = 2'd0,
    POL_RISE    = 2'd1,
    POL_FALL    = 2'd2,
    POL_OFF_ALT = 2'd3
  } pol_e;

  typedef enum logic [1:0] {
    GM_BLOCK  = 2'd0,
    GM_REPEAT = 2'd1,
    GM_LINK   = 2'd2,
    GM_BURST  = 2'd3
  } gmode_e;

  localparam int UNIT_N    = 5;
  localparam int U_BLOCK   = 0;
  localparam int U_REPEAT  = 1;
  localparam int U_LINK    = 2;
  localparam int U_RDBURST = 3;
  localparam int U_PBURST  = 4;

  // Edge qualification for the chosen polarity.
  function automatic logic edge_seen(input logic [1:0] pol, input logic cur, input logic prv);
    logic r;
    case (pol)
      POL_RISE: r = cur & ~prv;
      POL_FALL: r = ~cur & prv;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

  // One-hot mask of the unit kind that must spend a hit.
  function automatic logic [UNIT_N-1:0] gate_select(input logic [1:0] mode, input logic sw,
                                                     input logic rpt_ok);
    logic [UNIT_N-1:0] m;
    m = '0;
    case (mode)
      GM_BLOCK:  m[U_BLOCK] = 1'b1;
      GM_REPEAT: if (rpt_ok) m[U_REPEAT] = 1'b1; else m[U_BLOCK] = 1'b1;
      GM_LINK:   m[U_LINK] = 1'b1;
      default:   if (sw) m[U_RDBURST] = 1'b1; else m[U_PBURST] = 1'b1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/trg_sync.sv
module trg_sync #(
  parameter int N_TRIG      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRIG-1:0] async_in,
  output logic [N_TRIG-1:0] sync_out
);

  for (genvar i = 0; i < N_TRIG; i++) begin : g_line
    logic [SYNC_STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
      end else begin
        chain[0] <= async_in[i];
        for (int k = 1; k < SYNC_STAGES; k++) begin
          chain[k] <= chain[k-1];
        end
      end
    end

    assign sync_out[i] = chain[SYNC_STAGES-1];
  end

endmodule

// File: rtl/trg_edge.sv
module trg_edge
  import trgate_pkg::*;
#(
  parameter int N_TRIG = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRIG-1:0] lvl_vec,
  input  logic [SEL_W-1:0]  sel,
  input  logic [1:0]        pol,
  output logic              lvl_sel,
  output logic              hit
);

  localparam int PAD_N = 1 << SEL_W;

  logic [PAD_N-1:0] lvl_pad;
  logic             lvl_prev;

  if (PAD_N > N_TRIG) begin : g_pad
    assign lvl_pad = {{(PAD_N-N_TRIG){1'b0}}, lvl_vec};
  end else begin : g_nopad
    assign lvl_pad = lvl_vec;
  end

  assign lvl_sel = lvl_pad[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= 1'b0;
    else        lvl_prev <= lvl_sel;
  end

  assign hit = edge_seen(pol, lvl_sel, lvl_prev);

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pol == POL_OFF || pol == POL_OFF_ALT) |-> !hit); // R3
  AST_RISE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && pol == POL_RISE) |=> $past(lvl_sel)); // R3
  AST_FALL_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && pol == POL_FALL) |=> !$past(lvl_sel)); // R3

endmodule

// File: rtl/trg_hold.sv
module trg_hold #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             consume,
  output logic             pending,
  output logic             ovr_pulse,
  output logic [CNT_W-1:0] ovr_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  logic pending_d;

  assign ovr_pulse = hit & pending & ~consume;
  assign pending_d = hit | (pending & ~consume);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      ovr_cnt <= '0;
    end else begin
      pending <= pending_d;
      if (ovr_pulse) ovr_cnt <= sat_inc(ovr_cnt);
    end
  end

  AST_HIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pending); // R11
  AST_CONSUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !hit) |=> !pending); // R9
  AST_CONSUME_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> pending); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_pulse && ovr_cnt != CNT_MAX) |=> ovr_cnt == $past(ovr_cnt) + 1'b1); // R10
  AST_CNT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_pulse |=> $stable(ovr_cnt)); // R10
  AST_OVR_KEEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_pulse |=> pending); // R10

endmodule

// File: rtl/trig_gate_unit.sv
module trig_gate_unit
  import trgate_pkg::*;
#(
  parameter int N_TRIG      = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit RPT_CAPABLE = 1'b1,
  parameter int CNT_W       = 4,
  localparam int SEL_W      = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]  trig_sel,
  input  logic [1:0]        trig_pol,
  input  logic [1:0]        gate_mode,
  input  logic              sw_req,
  input  logic [4:0]        unit_req,
  output logic [4:0]        unit_permit,
  output logic              hit_pending,
  output logic              overrun,
  output logic [CNT_W-1:0]  overrun_count
);

  logic [N_TRIG-1:0] trig_sync;
  logic              lvl_sel;
  logic              hit;
  logic              consume;
  logic [UNIT_N-1:0] gate_mask;
  logic              gated_req;

  trg_sync #(.N_TRIG(N_TRIG), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(trig_in), .sync_out(trig_sync)
  );

  trg_edge #(.N_TRIG(N_TRIG), .SEL_W(SEL_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_vec(trig_sync), .sel(trig_sel),
    .pol(trig_pol), .lvl_sel(lvl_sel), .hit(hit)
  );

  assign gate_mask = gate_select(gate_mode, sw_req, RPT_CAPABLE);
  assign gated_req = |(unit_req & gate_mask);
  assign consume   = gated_req & hit_pending;

  trg_hold #(.CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .hit(hit), .consume(consume),
    .pending(hit_pending), .ovr_pulse(overrun), .ovr_cnt(overrun_count)
  );

  always_comb begin
    unit_permit = unit_req & ~gate_mask;
    if (hit_pending) unit_permit = unit_permit | (unit_req & gate_mask);
  end

  AST_ONE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gate_mask) == 1); // R4
  AST_PERMIT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_permit & ~unit_req) == '0); // R8
  AST_GATED_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (|(unit_permit & gate_mask)) |-> hit_pending); // R9
  AST_RPT_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!RPT_CAPABLE && gate_mode == GM_REPEAT) |-> gate_mask[U_BLOCK]); // R5
  AST_LINK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_mode == GM_LINK) |-> (unit_permit[U_BLOCK] == unit_req[U_BLOCK])); // R6
  AST_BURST_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_mode == GM_BURST && sw_req) |-> (unit_permit[U_PBURST] == unit_req[U_PBURST])); // R7

endmodule

// File: tb/sim_trig_gate_unit.sv
module sim_trig_gate_unit;
  localparam int NT = 8;
  localparam int SS = 2;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] trig_in = '0;
  logic [2:0]    trig_sel = '0;
  logic [1:0]    trig_pol = '0;
  logic [1:0]    gate_mode = '0;
  logic          sw_req = 1'b0;
  logic [4:0]    unit_req = '0;
  logic [4:0]    perm0, perm1;
  logic          pend0, pend1, ovr0, ovr1;
  logic [CW-1:0] cnt0, cnt1;

  trig_gate_unit #(.N_TRIG(NT), .SYNC_STAGES(SS), .RPT_CAPABLE(1'b1), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_sel(trig_sel), .trig_pol(trig_pol),
    .gate_mode(gate_mode), .sw_req(sw_req), .unit_req(unit_req), .unit_permit(perm0),
    .hit_pending(pend0), .overrun(ovr0), .overrun_count(cnt0)
  );

  trig_gate_unit #(.N_TRIG(NT), .SYNC_STAGES(SS), .RPT_CAPABLE(1'b0), .CNT_W(CW)) u1 (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_sel(trig_sel), .trig_pol(trig_pol),
    .gate_mode(gate_mode), .sw_req(sw_req), .unit_req(unit_req), .unit_permit(perm1),
    .hit_pending(pend1), .overrun(ovr1), .overrun_count(cnt1)
  );

  always #10 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R1";
  int    hist[NT][SS];
  int    m_prev = 0;
  int    m_pend[2] = '{0, 0};
  int    m_cnt[2] = '{0, 0};
  bit    done = 1'b0;

  task automatic chk(input string t, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  function automatic int gidx(input int mode, input int sw, input int rptok);
    if (mode == 0) return 0;
    if (mode == 1) return rptok ? 1 : 0;
    if (mode == 2) return 2;
    return sw ? 3 : 4;
  endfunction

  // Compare all outputs with the model, then advance the model over one edge.
  task automatic tick();
    int syn, hit, g, cons, ovr, ep, nx_pend[2], nx_cnt[2];
    logic [4:0] ap;
    int apd, ao, ac;
    #2;
    syn = hist[trig_sel][SS-1];
    hit = ((trig_pol == 1 && syn == 1 && m_prev == 0) ||
           (trig_pol == 2 && syn == 0 && m_prev == 1)) ? 1 : 0;
    for (int d = 0; d < 2; d++) begin
      g   = gidx(gate_mode, sw_req, (d == 0) ? 1 : 0);
      ap  = (d == 0) ? perm0 : perm1;
      apd = (d == 0) ? pend0 : pend1;
      ao  = (d == 0) ? ovr0 : ovr1;
      ac  = (d == 0) ? cnt0 : cnt1;
      for (int i = 0; i < 5; i++) begin
        ep = (unit_req[i] && (i != g || m_pend[d] == 1)) ? 1 : 0;
        chk((i == g) ? tag : "R8", ap[i], ep);
      end
      cons = (unit_req[g] && m_pend[d] == 1) ? 1 : 0;
      ovr  = (hit == 1 && m_pend[d] == 1 && cons == 0) ? 1 : 0;
      chk("R10", ao, ovr);
      chk(tag, apd, m_pend[d]);
      chk("R10", ac, m_cnt[d]);
      nx_pend[d] = (hit == 1) ? 1 : (cons == 1 ? 0 : m_pend[d]);
      nx_cnt[d]  = (ovr == 1 && m_cnt[d] < 15) ? m_cnt[d] + 1 : m_cnt[d];
    end
    if (!rst_n) begin
      foreach (hist[i, s]) hist[i][s] = 0;
      m_prev = 0;
      m_pend = '{0, 0};
      m_cnt  = '{0, 0};
    end else begin
      for (int i = 0; i < NT; i++) begin
        for (int s = SS - 1; s > 0; s--) hist[i][s] = hist[i][s-1];
        hist[i][0] = trig_in[i];
      end
      m_prev = syn;
      for (int d = 0; d < 2; d++) begin
        m_pend[d] = nx_pend[d];
        m_cnt[d]  = nx_cnt[d];
      end
    end
    @(negedge clk);
    #1;
  endtask

  task automatic run(input int n);
    repeat (n) tick();
  endtask

  initial begin
    foreach (hist[i, s]) hist[i][s] = 0;
    @(negedge clk);
    #1;
    // R1: reset state
    tag = "R1";
    unit_req = 5'b00001;
    run(3);
    chk("R1", pend0, 0);
    chk("R1", cnt0, 0);
    rst_n = 1'b1;
    unit_req = '0;
    run(2);

    // R4: block gating, rising edge on line 3, ungated descriptor request alongside
    tag = "R4"; gate_mode = 2'd0; trig_pol = 2'd1; trig_sel = 3'd3;
    unit_req = 5'b00101;
    run(3);
    chk("R4", perm0[0], 0);
    trig_in[3] = 1'b1;
    run(6);
    unit_req = '0;
    run(2);

    // R2: latency of a rising edge through the synchronizer
    tag = "R2";
    trig_in[3] = 1'b0;
    run(4);
    trig_in[3] = 1'b1;
    run(2);
    chk("R2", pend0, 0);
    tick();
    chk("R2", pend0, 1);
    // R9: one gated permit consumes the hit
    tag = "R9";
    unit_req = 5'b00001;
    tick();
    unit_req = '0;
    chk("R9", pend0, 0);
    run(2);

    // R3: falling edge, then the two masked codes
    tag = "R3"; trig_pol = 2'd2;
    trig_in[3] = 1'b0;
    run(5);
    chk("R3", pend0, 1);
    unit_req = 5'b00001; tick(); unit_req = '0;
    for (int p = 0; p < 4; p += 3) begin
      trig_pol = p[1:0];
      trig_in[3] = 1'b1; run(4);
      trig_in[3] = 1'b0; run(4);
      chk("R3", pend0, 0);
    end

    // R12: other lines ignored, then a select change
    tag = "R12"; trig_pol = 2'd1;
    for (int j = 0; j < NT; j++) begin
      if (j != 3) begin
        trig_in[j] = 1'b1; run(3);
        trig_in[j] = 1'b0; run(3);
      end
    end
    chk("R12", pend0, 0);
    trig_sel = 3'd5;
    trig_in[3] = 1'b1; run(5);
    chk("R12", pend0, 0);
    trig_in[5] = 1'b1; run(5);
    chk("R12", pend0, 1);
    unit_req = 5'b00001; tick(); unit_req = '0;
    trig_sel = 3'd3; trig_in[5] = 1'b0;
    run(3);

    // R5: repeated-block gating and fallback on the instance without support
    tag = "R5"; gate_mode = 2'd1;
    unit_req = 5'b00011;
    trig_in[3] = 1'b0; run(3);
    trig_in[3] = 1'b1; run(8);
    unit_req = '0; run(2);

    // R6: descriptor fetch gating
    tag = "R6"; gate_mode = 2'd2;
    unit_req = 5'b01101;
    trig_in[3] = 1'b0; run(3);
    chk("R6", perm0[2], 0);
    trig_in[3] = 1'b1; run(8);
    unit_req = '0; run(2);

    // R7: burst gating, both request sources
    tag = "R7"; gate_mode = 2'd3;
    for (int s = 1; s >= 0; s--) begin
      sw_req = s[0];
      unit_req = 5'b11000;
      trig_in[3] = 1'b0; run(3);
      trig_in[3] = 1'b1; run(8);
      unit_req = '0; run(2);
    end

    // R10: overruns saturate, extra hits are not queued
    tag = "R10"; gate_mode = 2'd0; sw_req = 1'b0;
    for (int k = 0; k < 20; k++) begin
      trig_in[3] = 1'b0; run(3);
      trig_in[3] = 1'b1; run(3);
    end
    chk("R10", cnt0, 15);
    unit_req = 5'b00001; run(3); unit_req = '0;
    chk("R10", pend0, 0);

    // R11: request placed at several offsets against a fresh edge
    tag = "R11";
    for (int off = 0; off < 5; off++) begin
      trig_in[3] = 1'b0; run(3);
      trig_in[3] = 1'b1; run(4);
      trig_in[3] = 1'b0; run(3);
      trig_in[3] = 1'b1;
      run(off);
      unit_req = 5'b00001; tick(); unit_req = '0;
      if (off == 2) chk("R11", pend0, 1);
      run(5);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule